// File: doc/BRIEF.md
# DRAM Controller Event Counter Unit

This block is a memory-mapped performance monitor that sits beside a DRAM controller. It keeps eight 32-bit counters, and each one is fixed to a single controller event. The events are, by index: 0 write data beats, 1 read data beats, 2 write commands, 3 read commands, 4 precharge commands, 5 activate commands, 6 rank switches and 7 read/write turnarounds. No event selection logic exists. Each counter sits at its own fixed address, and the addresses leave gaps.

Software uses a plain 32-bit register port. Through it, software sets a global run bit and the per-counter enables, and it can preload or read any counter. An overflow flag is set when a counter wraps. Each flag can be masked before it reaches a single level-sensitive interrupt line. Software acknowledges flags one bit at a time with a write-one-to-clear register. A read-only version word identifies the block's revision.

Top module: `dram_evt_monitor`

## Requirements
- R1: Counter n counts event input bit n. Its word sits at byte offset 0x380, 0x384, 0x388, 0x38C, 0x3C0, 0x3C4, 0x3CC or 0x3D0 for n = 0 to 7 in that order. No other offset reads a counter, and 0x3C8 is unmapped.
- R2: A counter adds one on each rising clock edge where its event bit is 1, control bit 1 is 1 and its enable bit is 1. In every other case the counter holds its value.
- R3: A counter that increments from 0xFFFFFFFF becomes 0 and sets status bit n.
- R4: A write to a counter's offset loads the 32-bit data. A write takes priority over an event in the same cycle.
- R5: The control word at 0x010 keeps all 32 written bits and reads them back. Only bit 1, the global run bit, has an effect.
- R6: The enable word at 0x6C0 and the mask word at 0x6C8 each hold one bit per counter in bits 7:0, with bit n for counter n. A mask bit of 1 blocks that counter's overflow from reaching the interrupt.
- R7: irq_o is 1 exactly when some status bit is 1 and its mask bit is 0.
- R8: The status word at 0x6CC is read-only. Writing 1 in bit n of 0x6D0 clears only status bit n, and 0x6D0 reads as 0. If a wrap and a clear of the same bit occur in one cycle, the bit stays set.
- R9: Offset 0x710 returns the VERSION parameter, and writes to it have no effect.
- R10: After reset, the counters, control, enables, status and rdata_o are 0 and the mask is 0xFF. Unmapped offsets read 0 and ignore writes.
- R11: A read sampled at a rising edge presents its data on rdata_o after that edge. The data shows the state from before any count or write at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| evt_i | input | 8 | Single-cycle event pulses, bit n for counter n |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The assertions assume that each register access is a single-cycle strobe with a stable address and stable data. They also assume that the event inputs are clean synchronous pulses, with no meaning attached to how long a pulse lasts beyond one cycle per count. The stimulus follows these assumptions. It changes all inputs only on the falling clock edge and holds every access for exactly one cycle. It drives events either as isolated strobes or as patterned bursts whose counts the bench adds up bit by bit. Wrap, load and clear collisions are staged on purpose in a single cycle, because that is where the priority rules matter.

// File: rtl/dram_evt_pkg.sv
package dram_evt_pkg;
  localparam int NUM_CNT = 8;
  localparam int CNT_W   = 32;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;

  localparam logic [11:0] CTRL_OFS = 12'h010;
  localparam logic [11:0] EN_OFS   = 12'h6C0;
  localparam logic [11:0] MASK_OFS = 12'h6C8;
  localparam logic [11:0] STAT_OFS = 12'h6CC;
  localparam logic [11:0] CLR_OFS  = 12'h6D0;
  localparam logic [11:0] VER_OFS  = 12'h710;

  localparam int RUN_BIT = 1;

  // fixed counter placement; indices beyond the first eight fall into a spare window
  function automatic logic [11:0] cnt_ofs(input int idx);
    case (idx)
      0: return 12'h380;
      1: return 12'h384;
      2: return 12'h388;
      3: return 12'h38C;
      4: return 12'h3C0;
      5: return 12'h3C4;
      6: return 12'h3CC;
      7: return 12'h3D0;
      default: return 12'h400 + 12'(idx * 4);
    endcase
  endfunction
endpackage

// File: rtl/dram_evt_counter.sv
module dram_evt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_i,
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc   = run_i & evt_i & ~wr_i;
  assign ovf_o = inc & (&cnt_q);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (wr_i) cnt_q <= wdata_i;
    else if (inc)  cnt_q <= cnt_q + 1'b1;
  end

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !(run_i && evt_i)) |=> $stable(cnt_o));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && evt_i && !wr_i) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));
  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> (cnt_o == '0));
  a_r4_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i)));
endmodule

// File: rtl/dram_evt_irq.sv
module dram_evt_irq #(
  parameter int NUM_CNT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CNT-1:0] ovf_i,
  input  logic [NUM_CNT-1:0] clr_i,
  input  logic [NUM_CNT-1:0] mask_i,
  output logic [NUM_CNT-1:0] stat_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] stat_q;

  // set beats clear on collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | ovf_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & ~mask_i);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ovf_i) |=> ((stat_o & $past(ovf_i)) == $past(ovf_i)));
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|clr_i) |=> ((stat_o & $past(clr_i & ~ovf_i)) == '0));
  a_r7_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask_i) |-> !irq_o);
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i == '0) |=> ((stat_o & $past(stat_o)) == $past(stat_o)));
endmodule

// File: rtl/dram_evt_regs.sv
module dram_evt_regs
  import dram_evt_pkg::*;
#(
  parameter int          NUM_CNT = 8,
  parameter int          CNT_W   = 32,
  parameter int          ADDR_W  = 12,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_i,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_CNT-1:0]            stat_i,
  output logic                          run_o,
  output logic [NUM_CNT-1:0]            en_o,
  output logic [NUM_CNT-1:0]            mask_o,
  output logic [NUM_CNT-1:0]            cnt_wr_o,
  output logic [NUM_CNT-1:0]            clr_o,
  output logic [DATA_W-1:0]             rdata_o
);
  logic [DATA_W-1:0]  ctrl_q, rdata_q, rd_d;
  logic [NUM_CNT-1:0] en_q, mask_q, hit_cnt;
  logic               wr, rd;
  logic               hit_ctrl, hit_en, hit_mask, hit_stat, hit_clr, hit_ver;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  assign hit_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign hit_en   = (addr_i == ADDR_W'(EN_OFS));
  assign hit_mask = (addr_i == ADDR_W'(MASK_OFS));
  assign hit_stat = (addr_i == ADDR_W'(STAT_OFS));
  assign hit_clr  = (addr_i == ADDR_W'(CLR_OFS));
  assign hit_ver  = (addr_i == ADDR_W'(VER_OFS));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
    assign hit_cnt[g]  = (addr_i == ADDR_W'(cnt_ofs(g)));
    assign cnt_wr_o[g] = wr & hit_cnt[g];
  end

  assign clr_o = (wr && hit_clr) ? wdata_i[NUM_CNT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      en_q   <= '0;
      mask_q <= '1;
    end else if (wr) begin
      if (hit_ctrl) ctrl_q <= wdata_i;
      if (hit_en)   en_q   <= wdata_i[NUM_CNT-1:0];
      if (hit_mask) mask_q <= wdata_i[NUM_CNT-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    if (hit_ctrl) rd_d = ctrl_q;
    if (hit_en)   rd_d = DATA_W'(en_q);
    if (hit_mask) rd_d = DATA_W'(mask_q);
    if (hit_stat) rd_d = DATA_W'(stat_i);
    if (hit_ver)  rd_d = VERSION;
    for (int n = 0; n < NUM_CNT; n++)
      if (hit_cnt[n]) rd_d = DATA_W'(cnt_i[n]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_d;
  end

  assign run_o   = ctrl_q[RUN_BIT];
  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;

  a_r5_ctrl_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && hit_ctrl) |=> (ctrl_q == $past(wdata_i)));
  a_r9_version: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_ver) |=> (rdata_o == VERSION));
  a_r8_clr_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && hit_clr) |=> (rdata_o == '0));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
endmodule

// File: rtl/dram_evt_monitor.sv
module dram_evt_monitor
  import dram_evt_pkg::*;
#(
  parameter int          NUM_CNT = dram_evt_pkg::NUM_CNT,
  parameter int          CNT_W   = dram_evt_pkg::CNT_W,
  parameter int          ADDR_W  = dram_evt_pkg::ADDR_W,
  parameter logic [31:0] VERSION = 32'h0001_0203
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_CNT-1:0] evt_i,
  output logic               irq_o
);
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt;
  logic [NUM_CNT-1:0]            en, mask, cnt_wr, clr, stat, ovf;
  logic                          run;

  dram_evt_regs #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .VERSION(VERSION)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_i    (cnt),
    .stat_i   (stat),
    .run_o    (run),
    .en_o     (en),
    .mask_o   (mask),
    .cnt_wr_o (cnt_wr),
    .clr_o    (clr),
    .rdata_o  (rdata_o)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    dram_evt_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .evt_i   (evt_i[g]),
      .run_i   (run & en[g]),
      .wr_i    (cnt_wr[g]),
      .wdata_i (wdata_i[CNT_W-1:0]),
      .cnt_o   (cnt[g]),
      .ovf_o   (ovf[g])
    );
  end

  dram_evt_irq #(.NUM_CNT(NUM_CNT)) i_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ovf_i  (ovf),
    .clr_i  (clr),
    .mask_i (mask),
    .stat_o (stat),
    .irq_o  (irq_o)
  );

  a_r2_run_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !(req_i && we_i)) |=> $stable(cnt));
  a_r7_irq_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat != '0));
endmodule

// File: tb/test_dram_evt_monitor.sv
`timescale 1ns/1ps
module test_dram_evt_monitor;
  localparam logic [31:0] VER = 32'h0001_0203;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  evt_i = '0;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_cnt [8];

  always #2 clk_i = ~clk_i;

  dram_evt_monitor #(.VERSION(VER)) i_dram_evt_monitor (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .evt_i(evt_i), .irq_o(irq_o)
  );

  function automatic logic [11:0] ofs(input int n);
    logic [11:0] t [8] = '{12'h380, 12'h384, 12'h388, 12'h38C,
                           12'h3C0, 12'h3C4, 12'h3CC, 12'h3D0};
    return t[n];
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle; caller is at a falling edge, returns at the next falling edge
  task automatic cyc(input bit rq, input bit w, input logic [11:0] a,
                     input logic [31:0] d, input logic [7:0] e);
    req_i = rq; we_i = w; addr_i = a; wdata_i = d; evt_i = e;
    @(posedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; evt_i = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 8'h00);
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    cyc(1'b1, 1'b0, a, 32'h0, 8'h00);
    chk(req, rdata_o, exp);
  endtask

  task automatic pulse(input logic [7:0] e, input int k, input logic [7:0] en, input bit run);
    for (int c = 0; c < k; c++) begin
      cyc(1'b0, 1'b0, 12'h0, 32'h0, e);
      if (run) for (int n = 0; n < 8; n++) if (e[n] && en[n]) exp_cnt[n] += 1;
    end
  endtask

  task automatic chk_all(input string req);
    for (int n = 0; n < 8; n++) rd_chk(req, ofs(n), exp_cnt[n]);
  endtask

  initial begin
    int cyc_n = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc_n++;
      if (cyc_n > 150000) begin
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    for (int n = 0; n < 8; n++) exp_cnt[n] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk("R10 rdata", rdata_o, 32'h0);
    chk("R10 irq", {31'h0, irq_o}, 32'h0);
    chk_all("R10 counter");
    rd_chk("R10 ctrl", 12'h010, 32'h0);
    rd_chk("R10 en", 12'h6C0, 32'h0);
    rd_chk("R10 mask", 12'h6C8, 32'hFF);
    rd_chk("R10 stat", 12'h6CC, 32'h0);
    rd_chk("R9 version", 12'h710, VER);
    rd_chk("R1 gap 0x3C8", 12'h3C8, 32'h0);
    rd_chk("R10 unmapped", 12'h6C4, 32'h0);

    // R5 / R2: run bit clear stops all counting
    wr(12'h6C0, 32'hFF);
    wr(12'h010, 32'hA5A5_0000);
    rd_chk("R5 ctrl keep", 12'h010, 32'hA5A5_0000);
    pulse(8'hFF, 5, 8'hFF, 1'b0);
    chk_all("R2 run off");
    wr(12'h010, 32'hA5A5_0002);
    rd_chk("R5 ctrl run", 12'h010, 32'hA5A5_0002);

    // R1 / R2: one enable at a time, distinct counts
    for (int n = 0; n < 8; n++) begin
      wr(12'h6C0, 32'(1 << n));
      pulse(8'hFF, n + 3, 8'(1 << n), 1'b1);
    end
    chk_all("R1 map");

    // R2: patterned bursts with all enabled
    wr(12'h6C0, 32'hFF);
    for (int c = 0; c < 16; c++) pulse(8'((c * 37 + 11) & 8'hFF), 1, 8'hFF, 1'b1);
    chk_all("R2 pattern");
    wr(12'h6C0, 32'h5A);
    for (int c = 0; c < 12; c++) pulse(8'((c * 91 + 3) & 8'hFF), 1, 8'h5A, 1'b1);
    chk_all("R2 enable subset");

    // R2 global stop again
    wr(12'h010, 32'hA5A5_0000);
    pulse(8'hFF, 4, 8'h5A, 1'b0);
    chk_all("R2 stop");
    wr(12'h010, 32'hA5A5_0002);

    // R4: load wins over same-cycle event
    wr(12'h6C0, 32'hFF);
    for (int n = 0; n < 8; n++) begin
      cyc(1'b1, 1'b1, ofs(n), 32'h1234_5600 + 32'(n), 8'hFF);
      for (int m = 0; m < 8; m++) if (m != n) exp_cnt[m] += 1;
      exp_cnt[n] = 32'h1234_5600 + 32'(n);
    end
    chk_all("R4 load");

    // R3 / R6 / R7 / R8 per counter
    for (int n = 0; n < 8; n++) begin
      wr(12'h6C0, 32'(1 << n));
      wr(12'h6C8, 32'(8'hFF & ~(8'(1 << n))));
      wr(ofs(n), 32'hFFFF_FFFE);
      exp_cnt[n] = 32'hFFFF_FFFE;
      pulse(8'(1 << n), 3, 8'(1 << n), 1'b1);
      rd_chk("R3 wrap value", ofs(n), 32'h1);
      rd_chk("R3 status", 12'h6CC, 32'(1 << n));
      chk("R7 irq unmasked", {31'h0, irq_o}, 32'h1);
      wr(12'h6C8, 32'hFF);
      chk("R6 irq masked", {31'h0, irq_o}, 32'h0);
      wr(12'h6CC, 32'h0);
      rd_chk("R8 status read-only", 12'h6CC, 32'(1 << n));
      wr(12'h6D0, 32'(8'hFF & ~(8'(1 << n))));
      rd_chk("R8 other bits no clear", 12'h6CC, 32'(1 << n));
      wr(12'h6D0, 32'(1 << n));
      rd_chk("R8 clear", 12'h6CC, 32'h0);
    end
    chk_all("R3 others untouched");

    // R8 set wins over same-cycle clear
    wr(12'h6C0, 32'h01);
    wr(12'h6C8, 32'h00);
    wr(12'h380, 32'hFFFF_FFFF);
    cyc(1'b1, 1'b1, 12'h6D0, 32'h01, 8'h01);
    exp_cnt[0] = 32'h0;
    rd_chk("R8 set wins", 12'h6CC, 32'h01);
    chk("R7 irq level", {31'h0, irq_o}, 32'h1);
    rd_chk("R8 clr reads zero", 12'h6D0, 32'h0);
    wr(12'h6D0, 32'hFF);
    chk("R7 irq drops", {31'h0, irq_o}, 32'h0);

    // R9 / R10 writes ignored
    wr(12'h710, 32'h0);
    rd_chk("R9 version ro", 12'h710, VER);
    wr(12'h3C8, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped write", 12'h3C8, 32'h0);
    chk_all("R10 unmapped no side effect");

    // R11: read sees pre-edge value while counting at that edge
    cyc(1'b1, 1'b0, 12'h380, 32'h0, 8'h01);
    chk("R11 pre-edge", rdata_o, exp_cnt[0]);
    exp_cnt[0] += 1;
    rd_chk("R11 post-edge", 12'h380, exp_cnt[0]);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule